// File: doc/BRIEF.md
# ECC Error Interrupt Status Controller

This block gathers error event pulses from the error-correction logic of three protected memories: the transmit FIFO, the receive FIFO and the descriptor cache. Each memory reports two kinds of event. One is a corrected single-bit error (SEC). The other is a detected but uncorrectable double-bit error (DED). That gives six sources. Each source pulse sets a sticky status bit. A separate enable word selects which status bits may raise the single level-high interrupt line.

Software services the interrupt in three steps. It reads the status word, handles the pending causes, and writes the same value back to clear them. The status word is write-one-to-clear. Next to the status logic, one 8-bit saturating counter per source records how many error events that source has seen. The six counters are packed into two read-only counter words. All access goes through a single-cycle register port. A write takes effect at the clock edge where `reg_wr` is high. Read data is a combinational function of `reg_addr` and the current register state.

Top module: `ecc_irq_ctrl`

## Requirements
- R1: After reset, the status word, the enable word and both counter words read zero, and `irq` is low.
- R2: A high `err_evt[i]` in a cycle sets status bit i at the next clock edge, and the bit stays set until software clears it. Source positions are: 0 descriptor DED, 1 descriptor SEC, 2 receive DED, 3 receive SEC, 4 transmit DED, 5 transmit SEC. The status word is at offset 0x30, and bits 31:6 read zero.
- R3: A write to offset 0x30 clears each status bit whose data bit is 1. Status bits whose data bit is 0 are unchanged.
- R4: If a source event and a clearing write for the same status bit fall in the same cycle, the bit stays set.
- R5: The enable word at offset 0x34 is read/write. It stores data bits 5:0 in the status bit positions, and bits 31:6 read zero.
- R6: `irq` is high exactly when some status bit and its enable bit are both 1, and it is low otherwise.
- R7: Each source counter adds one for every cycle its `err_evt` bit is high. Counter word 0 is at offset 0x3C: transmit SEC in bits 7:0, transmit DED in 15:8, receive SEC in 23:16, receive DED in 31:24. Counter word 1 is at offset 0x40: descriptor SEC in bits 7:0, descriptor DED in 15:8, and zero above.
- R8: A counter that reaches 255 holds at 255 on further events.
- R9: Writes to the counter words or to unmapped offsets change no register. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_evt | input | 6 | Per-source error event pulses, in status bit order |
| reg_addr | input | 8 | Register byte offset for reads and writes |
| reg_wr | input | 1 | Write strobe, one write per high cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Level interrupt: any enabled status bit set |

## Verification
The bound checker checks the following on every cycle:
- every event lands in its status bit one edge later, even when a clear hits that bit in the same cycle;
- a status bit falls only on a write to the status offset;
- each counter moves by at most one, stays still when its source is idle, and never leaves 255;
- an all-zero enable write drops `irq` at the next edge.

The directed scenarios cover what a property cannot show easily:
- the exact packing of the six counters into the two words;
- the read-back masking of the enable word;
- the selective clearing pattern of a write-one-to-clear;
- the read-only behaviour of the counter words and unmapped offsets;
- the full run of one counter up to saturation.

// File: rtl/ecc_irq_pkg.sv
package ecc_irq_pkg;
  localparam int unsigned NUM_SRC = 6;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned DATA_W  = 32;

  // Source index = status/enable bit position; the order is software-visible.
  typedef enum int unsigned {
    SRC_DESC_DED = 0,
    SRC_DESC_SEC = 1,
    SRC_RX_DED   = 2,
    SRC_RX_SEC   = 3,
    SRC_TX_DED   = 4,
    SRC_TX_SEC   = 5
  } src_e;

  localparam logic [ADDR_W-1:0] OFF_STATUS = 8'h30;
  localparam logic [ADDR_W-1:0] OFF_ENABLE = 8'h34;
  localparam logic [ADDR_W-1:0] OFF_CNT_LO = 8'h3C;
  localparam logic [ADDR_W-1:0] OFF_CNT_HI = 8'h40;
endpackage

// File: rtl/ecc_sticky_status.sv
module ecc_sticky_status #(
  parameter int unsigned N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  // Clear first, then set: a same-cycle event survives the clear.
  always_ff @(posedge clk) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= (q_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/ecc_sat_counter.sv
module ecc_sat_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] MAX_VAL = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)                        q_o <= '0;
    else if (inc_i && q_o != MAX_VAL)  q_o <= q_o + 1'b1;
  end
endmodule

// File: rtl/ecc_reg_readback.sv
module ecc_reg_readback
  import ecc_irq_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [NUM_SRC-1:0]       status_i,
  input  logic [NUM_SRC-1:0]       enable_i,
  input  logic [NUM_SRC*CNT_W-1:0] cnt_i,
  output logic [DATA_W-1:0]        rdata_o
);
  logic [4*CNT_W-1:0] word_lo;
  logic [2*CNT_W-1:0] word_hi;

  assign word_lo = {cnt_i[SRC_RX_DED*CNT_W +: CNT_W],
                    cnt_i[SRC_RX_SEC*CNT_W +: CNT_W],
                    cnt_i[SRC_TX_DED*CNT_W +: CNT_W],
                    cnt_i[SRC_TX_SEC*CNT_W +: CNT_W]};
  assign word_hi = {cnt_i[SRC_DESC_DED*CNT_W +: CNT_W],
                    cnt_i[SRC_DESC_SEC*CNT_W +: CNT_W]};

  always_comb begin
    unique case (addr_i)
      OFF_STATUS: rdata_o = DATA_W'(status_i);
      OFF_ENABLE: rdata_o = DATA_W'(enable_i);
      OFF_CNT_LO: rdata_o = DATA_W'(word_lo);
      OFF_CNT_HI: rdata_o = DATA_W'(word_hi);
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ecc_irq_ctrl.sv
module ecc_irq_ctrl
  import ecc_irq_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] err_evt,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               irq
);
  logic                     wr_status;
  logic                     wr_enable;
  logic [NUM_SRC-1:0]       clr_mask;
  logic [NUM_SRC-1:0]       status_q;
  logic [NUM_SRC-1:0]       enable_q;
  logic [NUM_SRC*CNT_W-1:0] cnt_flat;
  logic                     unused_wdata_hi;

  assign wr_status       = reg_wr && (reg_addr == OFF_STATUS);
  assign wr_enable       = reg_wr && (reg_addr == OFF_ENABLE);
  assign clr_mask        = wr_status ? reg_wdata[NUM_SRC-1:0] : '0;
  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:NUM_SRC];

  ecc_sticky_status #(.N(NUM_SRC)) u_status (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (err_evt),
    .clr_i (clr_mask),
    .q_o   (status_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         enable_q <= '0;
    else if (wr_enable) enable_q <= reg_wdata[NUM_SRC-1:0];
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_cnt
    ecc_sat_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc_i (err_evt[s]),
      .q_o   (cnt_flat[s*CNT_W +: CNT_W])
    );
  end

  ecc_reg_readback #(.CNT_W(CNT_W)) u_rdback (
    .addr_i   (reg_addr),
    .status_i (status_q),
    .enable_i (enable_q),
    .cnt_i    (cnt_flat),
    .rdata_o  (reg_rdata)
  );

  assign irq = |(status_q & enable_q);
endmodule

// File: rtl/ecc_irq_ctrl_chk.sv
module ecc_irq_ctrl_chk
  import ecc_irq_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_SRC-1:0]       err_evt,
  input logic [ADDR_W-1:0]        reg_addr,
  input logic                     reg_wr,
  input logic [DATA_W-1:0]        reg_wdata,
  input logic                     irq,
  input logic [NUM_SRC-1:0]       status_q,
  input logic [NUM_SRC*CNT_W-1:0] cnt_flat
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  // R2 and R4: every event is visible one edge later, clear or not
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt != '0) |=> ((status_q & $past(err_evt)) == $past(err_evt)));

  // R3: status bits fall only through a status write
  a_r3_only_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == OFF_STATUS) |=> ((status_q & $past(status_q)) == $past(status_q)));

  // R6: an all-zero enable write silences the interrupt
  a_r6_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFF_ENABLE && reg_wdata[NUM_SRC-1:0] == '0) |=> !irq);

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_cnt_chk
    // R7: idle source leaves its counter untouched
    a_r7_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !err_evt[s] |=> $stable(cnt_flat[s*CNT_W +: CNT_W]));
    // R7: a counter moves by at most one per edge
    a_r7_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (cnt_flat[s*CNT_W +: CNT_W] == $past(cnt_flat[s*CNT_W +: CNT_W]) ||
                cnt_flat[s*CNT_W +: CNT_W] == $past(cnt_flat[s*CNT_W +: CNT_W]) + 1'b1));
    // R8: saturation holds
    a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_flat[s*CNT_W +: CNT_W] == CMAX) |=> (cnt_flat[s*CNT_W +: CNT_W] == CMAX));
  end
endmodule

bind ecc_irq_ctrl ecc_irq_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .err_evt   (err_evt),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .irq       (irq),
  .status_q  (status_q),
  .cnt_flat  (cnt_flat)
);

// File: tb/test_ecc_irq_ctrl.sv
`timescale 1ns/1ps
module test_ecc_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  err_evt = '0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // Reference state from the requirements
  logic [5:0] m_st = '0;
  logic [5:0] m_en = '0;
  int         m_cnt [6];

  always #5 clk = ~clk;

  ecc_irq_ctrl i_ecc_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .err_evt(err_evt), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One clock of stimulus; the model follows R2..R9
  task automatic cyc(input logic [5:0] evt, input logic wr, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    err_evt = evt; reg_wr = wr; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    err_evt = '0; reg_wr = 1'b0;
    if (wr && a == 8'h30) m_st = m_st & ~d[5:0];
    if (wr && a == 8'h34) m_en = d[5:0];
    m_st = m_st | evt;
    for (int i = 0; i < 6; i++)
      if (evt[i] && m_cnt[i] < 255) m_cnt[i]++;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] cnt_lo();
    return {m_cnt[2][7:0], m_cnt[3][7:0], m_cnt[4][7:0], m_cnt[5][7:0]};
  endfunction
  function automatic logic [31:0] cnt_hi();
    return {16'h0, m_cnt[0][7:0], m_cnt[1][7:0]};
  endfunction

  task automatic check_all(input string tag);
    logic [31:0] v;
    rd(8'h30, v); chk({tag, " status"}, v, {26'h0, m_st});
    rd(8'h34, v); chk({tag, " enable"}, v, {26'h0, m_en});
    rd(8'h3C, v); chk({tag, " cnt0"}, v, cnt_lo());
    rd(8'h40, v); chk({tag, " cnt1"}, v, cnt_hi());
    chk({tag, " irq"}, {31'h0, irq}, {31'h0, |(m_st & m_en)});
  endtask

  task automatic t_reset();
    check_all("R1");
  endtask

  task automatic t_set_each();
    logic [31:0] v;
    for (int i = 0; i < 6; i++) begin
      cyc(6'(1 << i), 1'b0, 8'h00, 32'h0);
      rd(8'h30, v); chk("R2 sticky set", v, {26'h0, m_st});
    end
    cyc(6'h00, 1'b0, 8'h00, 32'h0);
    rd(8'h30, v); chk("R2 held", v, 32'h3F);
    rd(8'h3C, v); chk("R7 cnt0 pack", v, 32'h01010101);
    rd(8'h40, v); chk("R7 cnt1 pack", v, 32'h00000101);
    chk("R6 no enable", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    cyc(6'h00, 1'b1, 8'h30, 32'hFFFF_FF05);
    rd(8'h30, v); chk("R3 clear 0,2", v, 32'h3A);
    cyc(6'h00, 1'b1, 8'h30, 32'h0);
    rd(8'h30, v); chk("R3 zero write", v, 32'h3A);
  endtask

  task automatic t_set_wins();
    logic [31:0] v;
    cyc(6'h02, 1'b1, 8'h30, 32'h0A);
    rd(8'h30, v); chk("R4 set wins", v, 32'h32);
    rd(8'h40, v); chk("R7 desc sec", v, cnt_hi());
  endtask

  task automatic t_enable();
    logic [31:0] v;
    cyc(6'h00, 1'b1, 8'h34, 32'hFFFF_FFC0);
    rd(8'h34, v); chk("R5 upper masked", v, 32'h0);
    cyc(6'h00, 1'b1, 8'h34, 32'h10);
    rd(8'h34, v); chk("R5 readback", v, 32'h10);
    #1 chk("R6 irq on", {31'h0, irq}, 32'h1);
    cyc(6'h00, 1'b1, 8'h30, 32'h10);
    #1 chk("R6 irq off after clear", {31'h0, irq}, 32'h0);
    cyc(6'h20, 1'b0, 8'h00, 32'h0);
    #1 chk("R6 disabled src", {31'h0, irq}, 32'h0);
    cyc(6'h10, 1'b0, 8'h00, 32'h0);
    #1 chk("R6 enabled src", {31'h0, irq}, 32'h1);
    cyc(6'h00, 1'b1, 8'h34, 32'h0);
    #1 chk("R6 all masked", {31'h0, irq}, 32'h0);
    check_all("R6 state");
  endtask

  task automatic t_saturate();
    logic [31:0] v;
    for (int k = 0; k < 300; k++) cyc(6'h20, 1'b0, 8'h00, 32'h0);
    rd(8'h3C, v); chk("R8 tx sec at 255", {24'h0, v[7:0]}, 32'hFF);
    chk("R8 word", v, cnt_lo());
    rd(8'h40, v); chk("R8 others", v, cnt_hi());
  endtask

  task automatic t_readonly();
    logic [31:0] v;
    cyc(6'h00, 1'b1, 8'h3C, 32'h0);
    cyc(6'h00, 1'b1, 8'h40, 32'hFFFF_FFFF);
    cyc(6'h00, 1'b1, 8'h44, 32'hFFFF_FFFF);
    cyc(6'h00, 1'b1, 8'h00, 32'hFFFF_FFFF);
    rd(8'h44, v); chk("R9 unmapped read", v, 32'h0);
    rd(8'h00, v); chk("R9 unmapped read 0", v, 32'h0);
    check_all("R9 unchanged");
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 6; i++) m_cnt[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_set_each();
    t_w1c();
    t_set_wins();
    t_enable();
    t_saturate();
    t_readonly();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule